// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block keeps a running tally of finished commands that asked to be announced by interrupt. It then decides when the completion interrupt line goes high. Each cycle a pulse from the completion path adds one to the tally. Software removes entries from the tally by writing an acknowledge amount. Software may also overwrite the tally directly, for diagnostics.

Two limits decide when a burst of completions is announced: a count limit and a hold-off time. The hold-off timer advances on a free-running tick while the tally is nonzero. It is cleared whenever the tally is zero, and it restarts on every acknowledge or direct write. The interrupt is re-evaluated in the cycle after an acknowledge. A completion that races with the acknowledge therefore raises the line again at once. An enable input masks the line without stopping the counting.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the tally reads 0 and the interrupt is low. Each cycle with `cmpl_pulse` high, and no acknowledge or direct write, raises the tally by one in the next cycle.
- R2: An acknowledge write (`ack_wr_en`) subtracts `ack_wr_data` from the tally. If the amount exceeds the tally, the tally becomes 0.
- R3: A completion pulse and an acknowledge in the same cycle give a single update: tally + 1 - amount, clamped at 0.
- R4: A direct write (`cnt_wr_en`) loads `cnt_wr_data` into the tally, plus one if a pulse arrives in the same cycle. It also restarts the hold-off timer from zero.
- R5: The tally saturates at 2^20-1 and does not wrap.
- R6: While the tally is 0 the hold-off timer is held at zero and the interrupt is low.
- R7: The interrupt rises when the tally is at least the count limit. The count limit is bits 19:0 of the wait register (`wait_wr_data`), and a limit of 0 acts as 1.
- R8: While the tally is nonzero the timer advances by one on each cycle with `tick` high. The interrupt rises when the timer reaches the hold-off limit × 1024. The hold-off limit is bits 47:32 of the wait register, and a limit of 0 disables the time trigger.
- R9: An acknowledge (of any amount, including 0) restarts the timer. In the cycle after it, the interrupt reflects the new tally: it stays high if the remainder still meets the count limit.
- R10: With `irq_en` low the interrupt is low, while the tally and timer keep updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_pulse | input | 1 | One finished command that requested an interrupt |
| tick | input | 1 | Free-running time-base strobe for the hold-off timer |
| ack_wr_en | input | 1 | Acknowledge write strobe |
| ack_wr_data | input | 20 | Amount to subtract from the tally |
| cnt_wr_en | input | 1 | Direct (diagnostic) tally write strobe |
| cnt_wr_data | input | 20 | Value for the direct write |
| wait_wr_en | input | 1 | Wait register write strobe |
| wait_wr_data | input | 64 | Wait register value: hold-off limit at 47:32, count limit at 19:0 |
| irq_en | input | 1 | Interrupt enable |
| done_cnt | output | 20 | Current tally (the value both registers read back) |
| irq | output | 1 | Completion interrupt level |

## Verification
Single pulses are stepped across the count limit. This separates a ≥ comparison from a > one, and checks that a zero limit is promoted to one. Acknowledges are tried in several forms: smaller than the tally, larger than it, of zero, and coinciding with a pulse. These show the difference between a net update and a lost event, between clamping and wrap-around, and between the timer restart and the immediate re-raise. The tally is left at zero for a long stretch before a single completion and a 1024-tick wait. The interrupt is expected exactly on the 1024th tick, which distinguishes a held timer from one that kept running. Masking, the disabled time trigger and a pulse at the saturation value each confirm that the tally keeps its expected value while the output is steered.

// File: rtl/cmpl_coal_pkg.sv
// Shared widths and field positions for the completion interrupt coalescer.
package cmpl_coal_pkg;
    parameter int CNT_W      = 20;   // tally width
    parameter int HOLD_W     = 16;   // hold-off limit field width
    parameter int TIME_SHIFT = 10;   // hold-off limit unit is 2^TIME_SHIFT ticks
    parameter int WAIT_W     = 64;   // wait register width
    parameter int HOLD_LSB   = 32;   // hold-off limit field position
    parameter int LIM_LSB    = 0;    // count limit field position
    localparam int TMR_W     = HOLD_W + TIME_SHIFT;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [HOLD_W-1:0] hold_t;
    typedef logic [TMR_W-1:0]  tmr_t;

    typedef struct packed {
        hold_t hold_lim;
        cnt_t  cnt_lim;
    } wait_cfg_t;
endpackage

// File: rtl/coal_tally.sv
// Completion tally. Merges pulse, acknowledge and direct write into one
// update per cycle. Assumes at most one pulse per cycle. Clamps at zero
// on over-acknowledge and saturates at the all-ones value.
module coal_tally
    import cmpl_coal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic ack_en,
    input  cnt_t ack_amt,
    input  logic load_en,
    input  cnt_t load_val,
    output cnt_t count
);
    localparam cnt_t CNT_MAX = '1;

    logic [CNT_W:0] sum_w;
    logic [CNT_W:0] base_w;
    cnt_t           next_w;

    // Form the net next value from all same-cycle sources.
    always_comb begin
        sum_w = {1'b0, count} + {{CNT_W{1'b0}}, inc};
        if (load_en)
            base_w = {1'b0, load_val} + {{CNT_W{1'b0}}, inc};
        else if (ack_en && sum_w <= {1'b0, ack_amt})
            base_w = '0;
        else if (ack_en)
            base_w = sum_w - {1'b0, ack_amt};
        else
            base_w = sum_w;
        next_w = base_w[CNT_W] ? CNT_MAX : base_w[CNT_W-1:0];
    end

    // Hold the tally.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= next_w;
    end
endmodule

// File: rtl/coal_holdoff_timer.sv
// Hold-off timer. Cleared while the tally is zero or on any restart
// request, otherwise advances on tick and saturates at all-ones.
module coal_holdoff_timer
    import cmpl_coal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tally_zero,
    input  logic restart,
    input  logic tick,
    output tmr_t tmr
);
    localparam tmr_t TMR_MAX = '1;

    // Advance, hold or clear the timer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tmr <= '0;
        else if (tally_zero || restart) tmr <= '0;
        else if (tick && tmr != TMR_MAX) tmr <= tmr + 1'b1;
    end
endmodule

// File: rtl/coal_wait_cfg.sv
// Wait register. Captures the two limit fields from a full-width write;
// bits outside the fields are dropped. Reset leaves both limits at zero.
module coal_wait_cfg
    import cmpl_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAIT_W-1:0] wr_data,
    output wait_cfg_t         cfg
);
    // Capture the limit fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.hold_lim <= wr_data[HOLD_LSB +: HOLD_W];
            cfg.cnt_lim  <= wr_data[LIM_LSB +: CNT_W];
        end
    end
endmodule

// File: rtl/cmpl_irq_coalescer.sv
// Completion interrupt coalescer top. Combines the tally, the hold-off
// timer and the wait register, and decides the interrupt level from
// registered state plus the enable input.
module cmpl_irq_coalescer
    import cmpl_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_pulse,
    input  logic              tick,
    input  logic              ack_wr_en,
    input  logic [CNT_W-1:0]  ack_wr_data,
    input  logic              cnt_wr_en,
    input  logic [CNT_W-1:0]  cnt_wr_data,
    input  logic              wait_wr_en,
    input  logic [WAIT_W-1:0] wait_wr_data,
    input  logic              irq_en,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              irq
);
    cnt_t      tally_q;
    tmr_t      tmr_q;
    wait_cfg_t cfg_q;
    cnt_t      lim_eff;
    logic      time_hit;
    logic      cnt_hit;

    coal_tally u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cmpl_pulse),
        .ack_en   (ack_wr_en),
        .ack_amt  (ack_wr_data),
        .load_en  (cnt_wr_en),
        .load_val (cnt_wr_data),
        .count    (tally_q)
    );

    coal_holdoff_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tally_zero (tally_q == '0),
        .restart    (ack_wr_en || cnt_wr_en),
        .tick       (tick),
        .tmr        (tmr_q)
    );

    coal_wait_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wait_wr_en),
        .wr_data (wait_wr_data),
        .cfg     (cfg_q)
    );

    // Decide the interrupt level from the two triggers and the mask.
    always_comb begin
        lim_eff  = (cfg_q.cnt_lim == '0) ? cnt_t'(1) : cfg_q.cnt_lim;
        time_hit = (cfg_q.hold_lim != '0) &&
                   (tmr_q >= {cfg_q.hold_lim, {TIME_SHIFT{1'b0}}});
        cnt_hit  = (tally_q >= lim_eff);
        irq      = irq_en && (tally_q != '0) && (time_hit || cnt_hit);
    end

    assign done_cnt = tally_q;
endmodule

// File: rtl/cmpl_irq_coalescer_chk.sv
// Property checker for the coalescer, bound to the top module.
module cmpl_irq_coalescer_chk
    import cmpl_coal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cmpl_pulse,
    input logic      ack_wr_en,
    input logic      cnt_wr_en,
    input logic      irq_en,
    input cnt_t      done_cnt,
    input logic      irq,
    input tmr_t      tmr,
    input wait_cfg_t cfg
);
    localparam cnt_t CNT_MAX = '1;

    assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_pulse && !ack_wr_en && !cnt_wr_en && done_cnt != CNT_MAX)
        |=> done_cnt == $past(done_cnt) + 1'b1);

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_pulse && !ack_wr_en && !cnt_wr_en && done_cnt == CNT_MAX)
        |=> done_cnt == CNT_MAX);

    assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt == '0) |-> !irq);

    assert_timer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt == '0) |=> tmr == '0);

    assert_count_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && done_cnt != '0 &&
         done_cnt >= ((cfg.cnt_lim == '0) ? cnt_t'(1) : cfg.cnt_lim)) |-> irq);

    assert_ack_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr_en |=> tmr == '0);

    assert_load_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> tmr == '0);

    assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind cmpl_irq_coalescer cmpl_irq_coalescer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmpl_pulse (cmpl_pulse),
    .ack_wr_en  (ack_wr_en),
    .cnt_wr_en  (cnt_wr_en),
    .irq_en     (irq_en),
    .done_cnt   (done_cnt),
    .irq        (irq),
    .tmr        (tmr_q),
    .cfg        (cfg_q)
);

// File: tb/sim_cmpl_irq_coalescer.sv
// Bench: behavioural reference model compared on every negative edge,
// plus directed checks at the boundaries named by the requirements.
module sim_cmpl_irq_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_pulse = 1'b0;
    logic        tick = 1'b0;
    logic        ack_wr_en = 1'b0;
    logic [19:0] ack_wr_data = '0;
    logic        cnt_wr_en = 1'b0;
    logic [19:0] cnt_wr_data = '0;
    logic        wait_wr_en = 1'b0;
    logic [63:0] wait_wr_data = '0;
    logic        irq_en = 1'b0;
    logic [19:0] done_cnt;
    logic        irq;

    int checks = 0;
    int errors = 0;

    longint m_cnt = 0, m_tmr = 0, m_hold = 0, m_lim = 0;
    localparam longint CMAX = 64'd1048575;
    localparam longint TMAX = 64'd67108863;

    always #2 clk = ~clk;

    cmpl_irq_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .tick(tick),
        .ack_wr_en(ack_wr_en), .ack_wr_data(ack_wr_data),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .wait_wr_en(wait_wr_en), .wait_wr_data(wait_wr_data),
        .irq_en(irq_en), .done_cnt(done_cnt), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_irq();
        longint lim;
        bit th;
        lim = (m_lim == 0) ? 1 : m_lim;
        th  = (m_hold != 0) && (m_tmr >= m_hold * 1024);
        return irq_en && (m_cnt != 0) && (th || m_cnt >= lim);
    endfunction

    // Reference model: advance on every rising edge.
    always @(posedge clk) begin
        longint s, n;
        if (!rst_n) begin
            m_cnt = 0; m_tmr = 0; m_hold = 0; m_lim = 0;
        end else begin
            if (m_cnt == 0 || ack_wr_en || cnt_wr_en) m_tmr = 0;
            else if (tick && m_tmr < TMAX) m_tmr = m_tmr + 1;
            s = m_cnt + (cmpl_pulse ? 1 : 0);
            if (cnt_wr_en) n = cnt_wr_data + (cmpl_pulse ? 1 : 0);
            else if (ack_wr_en) n = (s > ack_wr_data) ? s - ack_wr_data : 0;
            else n = s;
            m_cnt = (n > CMAX) ? CMAX : n;
            if (wait_wr_en) begin
                m_hold = wait_wr_data[47:32];
                m_lim  = wait_wr_data[19:0];
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done_cnt == m_cnt, "R1 tally vs model", done_cnt, m_cnt);
            chk(irq == model_irq(), "R7 irq vs model", irq, model_irq());
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cmpl_pulse = 0; ack_wr_en = 0; cnt_wr_en = 0; wait_wr_en = 0;
        end
    endtask

    task automatic set_wait(input longint hold, input longint lim);
        wait_wr_en = 1;
        wait_wr_data = (64'(hold) << 32) | 64'(lim);
        step(1);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin cmpl_pulse = 1; step(1); end
    endtask

    task automatic ack(input longint amt);
        ack_wr_en = 1; ack_wr_data = 20'(amt); step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1; step(1);
        chk(done_cnt == 0, "R1 reset tally", done_cnt, 0);
        chk(irq == 0, "R6 reset irq", irq, 0);

        irq_en = 1;
        set_wait(0, 4);
        pulse(3);
        chk(done_cnt == 3, "R1 three pulses", done_cnt, 3);
        chk(irq == 0, "R7 below limit", irq, 0);
        pulse(1);
        chk(irq == 1, "R7 at limit", irq, 1);
        pulse(1);
        ack(1);
        chk(done_cnt == 4, "R2 ack subtract", done_cnt, 4);
        chk(irq == 1, "R9 re-raise after ack", irq, 1);

        cmpl_pulse = 1; ack_wr_en = 1; ack_wr_data = 2; step(1);
        chk(done_cnt == 3, "R3 net update", done_cnt, 3);
        chk(irq == 0, "R7 dropped below", irq, 0);
        ack(10);
        chk(done_cnt == 0, "R2 clamp zero", done_cnt, 0);

        set_wait(0, 0);
        pulse(1);
        chk(irq == 1, "R7 zero limit acts as one", irq, 1);
        irq_en = 0; pulse(1);
        chk(done_cnt == 2, "R10 counting while masked", done_cnt, 2);
        chk(irq == 0, "R10 masked", irq, 0);
        irq_en = 1; step(1);
        chk(irq == 1, "R10 unmasked", irq, 1);

        ack(2);
        set_wait(1, 100);
        tick = 1;
        step(2000);
        chk(irq == 0, "R6 idle no irq", irq, 0);
        pulse(1);
        step(1023);
        chk(irq == 0, "R6 timer held before count", irq, 0);
        step(1);
        chk(irq == 1, "R8 time trigger", irq, 1);
        ack(0);
        chk(irq == 0, "R9 ack restarts timer", irq, 0);
        chk(done_cnt == 1, "R9 ack zero keeps tally", done_cnt, 1);
        step(1024);
        chk(irq == 1, "R8 time trigger again", irq, 1);

        cnt_wr_en = 1; cnt_wr_data = 7; cmpl_pulse = 1; step(1);
        chk(done_cnt == 8, "R4 direct write plus pulse", done_cnt, 8);
        chk(irq == 0, "R4 write restarts timer", irq, 0);

        set_wait(0, 100);
        step(1100);
        chk(irq == 0, "R8 zero hold disables", irq, 0);

        cnt_wr_en = 1; cnt_wr_data = 20'hFFFFF; step(1);
        pulse(1);
        chk(done_cnt == 20'hFFFFF, "R5 saturate", done_cnt, 64'hFFFFF);
        chk(irq == 1, "R7 high tally", irq, 1);

        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule